// File: doc/BRIEF.md
# IO Operation Queueing Bridge

This block sits between a load/store unit and a memory-mapped IO path. The load/store side offers IO operations, each made of a thread number, a small operation code, an address and a data word. The bridge accepts them into a request queue and presents the oldest one to the IO target. A request stays at the head of that queue until the target's reply for it is taken in. In the cycle the reply is taken, the head request is retired and a response entry is written into a second queue. That entry holds the reply data and the thread number of the retired request.

The oldest response is presented back to the load/store side together with the thread number that should be woken. The consumer removes it with a single-cycle consume pulse. Both queues default to eight entries. All data-carrying edges use valid/ready rules. A request moves when `io_req_valid` and `io_req_ready` are both high at a clock edge. A reply moves when `rpl_valid` and `rpl_ready` are both high at a clock edge. The response side is a valid/consume pair with no back-pressure on the bridge. When `io_req_ready` or `rpl_ready` is low, the offering side must hold its values or withdraw them. Nothing is taken.

Top module: `iob_bridge`

## Requirements
- R1: During reset and on the first cycle after it, `io_req_ready` is 1, `tgt_valid` is 0, `rpl_ready` is 0 and `rsp_valid` is 0.
- R2: `io_req_ready` is low exactly when REQ_DEPTH requests are outstanding. An offer made while it is low is dropped and never reaches the target.
- R3: `tgt_valid` is high whenever a request is outstanding. The `tgt_*` fields show the oldest outstanding request, in arrival order, and they stay stable until its reply is accepted.
- R4: A reply is accepted only at a clock edge where `rpl_valid` and `rpl_ready` are both high. At that edge the head request is retired and the response {thread of that request, `rpl_data`} is appended to the response queue.
- R5: `rsp_valid` is high whenever the response queue is non-empty. `rsp_thread` and `rsp_data` show the oldest response, and responses leave in the order their replies were accepted.
- R6: A one-cycle `rsp_consumed` pulse removes the oldest response at that edge. A pulse while `rsp_valid` is low is ignored.
- R7: A push and a pop of the same queue at the same edge are both carried out, and the occupancy stays the same. This holds for a request offer together with a reply, and for a reply together with a consume pulse.
- R8: While the response queue holds RSP_DEPTH entries, `rpl_ready` is low. The head request stays presented until space frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_req_valid | input | 1 | An IO operation is offered |
| io_req_ready | output | 1 | Request queue has room |
| io_req_thread | input | TID_W | Thread number of the offered operation |
| io_req_op | input | OP_W | Operation code |
| io_req_addr | input | ADDR_W | IO address |
| io_req_data | input | DATA_W | Write data |
| tgt_valid | output | 1 | Oldest request is presented to the target |
| tgt_thread | output | TID_W | Thread number of the presented request |
| tgt_op | output | OP_W | Operation code of the presented request |
| tgt_addr | output | ADDR_W | Address of the presented request |
| tgt_data | output | DATA_W | Data of the presented request |
| rpl_valid | input | 1 | Target offers the reply for the presented request |
| rpl_ready | output | 1 | Reply can be taken |
| rpl_data | input | DATA_W | Reply data |
| rsp_valid | output | 1 | A response is available |
| rsp_thread | output | TID_W | Thread to wake for the presented response |
| rsp_data | output | DATA_W | Response data |
| rsp_consumed | input | 1 | One-cycle pulse that removes the presented response |

## Verification
Two things can hit the same queue at the same edge. In the response queue, a reply can be written in while a consume pulse removes the head. In the request queue, a new offer can arrive while a reply retires the head. The bench provokes both with long runs where the offer, reply and consume inputs are asserted together. It does this with the queues partly filled and also with the response queue full. It then compares the presented heads and both ready outputs every cycle against a queue model that applies the pop and the push from the same old occupancy. A lost or doubled entry shows up as a wrong head or a wrong ready within a few cycles.

// File: rtl/iob_pkg.sv
package iob_pkg;
  parameter int TID_W  = 3;
  parameter int OP_W   = 2;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic [TID_W-1:0]  thread;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } io_req_t;

  typedef struct packed {
    logic [TID_W-1:0]  thread;
    logic [DATA_W-1:0] data;
  } io_rsp_t;

  localparam int REQ_W = $bits(io_req_t);
  localparam int RSP_W = $bits(io_rsp_t);
endpackage

// File: rtl/iob_fifo.sv
module iob_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  int gap_i;
  always_comb begin
    if (wr_ptr >= rd_ptr) gap_i = int'(wr_ptr) - int'(rd_ptr);
    else                  gap_i = int'(wr_ptr) + DEPTH - int'(rd_ptr);
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  // R5
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_i == (full ? 0 : int'(cnt)));

  // R7
  same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/iob_retire_ctrl.sv
module iob_retire_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_empty,
  input  logic rsp_full,
  input  logic rsp_empty,
  input  logic rpl_valid,
  input  logic consumed,
  output logic rpl_ready,
  output logic retire,
  output logic rsp_pop
);
  assign rpl_ready = !req_empty && !rsp_full;
  assign retire    = rpl_valid && rpl_ready;
  assign rsp_pop   = consumed && !rsp_empty;

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> !retire);
endmodule

// File: rtl/iob_bridge.sv
module iob_bridge
  import iob_pkg::*;
#(
  parameter int REQ_DEPTH = 8,
  parameter int RSP_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic [TID_W-1:0]  io_req_thread,
  input  logic [OP_W-1:0]   io_req_op,
  input  logic [ADDR_W-1:0] io_req_addr,
  input  logic [DATA_W-1:0] io_req_data,
  output logic              tgt_valid,
  output logic [TID_W-1:0]  tgt_thread,
  output logic [OP_W-1:0]   tgt_op,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  input  logic              rpl_valid,
  output logic              rpl_ready,
  input  logic [DATA_W-1:0] rpl_data,
  output logic              rsp_valid,
  output logic [TID_W-1:0]  rsp_thread,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_consumed
);
  io_req_t in_req, head_req;
  io_rsp_t new_rsp, head_rsp;
  logic [REQ_W-1:0] head_req_bits;
  logic [RSP_W-1:0] head_rsp_bits;
  logic req_full, req_empty, rsp_full, rsp_empty;
  logic retire, rsp_pop;

  assign in_req = '{thread: io_req_thread, op: io_req_op,
                    addr: io_req_addr, data: io_req_data};

  iob_fifo #(.WIDTH(REQ_W), .DEPTH(REQ_DEPTH)) req_q_i (
    .clk(clk), .rst_n(rst_n),
    .push(io_req_valid), .push_data(in_req),
    .pop(retire), .head(head_req_bits),
    .full(req_full), .empty(req_empty)
  );

  assign head_req = io_req_t'(head_req_bits);
  assign new_rsp  = '{thread: head_req.thread, data: rpl_data};

  iob_fifo #(.WIDTH(RSP_W), .DEPTH(RSP_DEPTH)) rsp_q_i (
    .clk(clk), .rst_n(rst_n),
    .push(retire), .push_data(new_rsp),
    .pop(rsp_pop), .head(head_rsp_bits),
    .full(rsp_full), .empty(rsp_empty)
  );

  assign head_rsp = io_rsp_t'(head_rsp_bits);

  iob_retire_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_empty(req_empty), .rsp_full(rsp_full), .rsp_empty(rsp_empty),
    .rpl_valid(rpl_valid), .consumed(rsp_consumed),
    .rpl_ready(rpl_ready), .retire(retire), .rsp_pop(rsp_pop)
  );

  assign io_req_ready = !req_full;
  assign tgt_valid    = !req_empty;
  assign tgt_thread   = head_req.thread;
  assign tgt_op       = head_req.op;
  assign tgt_addr     = head_req.addr;
  assign tgt_data     = head_req.data;
  assign rsp_valid    = !rsp_empty;
  assign rsp_thread   = head_rsp.thread;
  assign rsp_data     = head_rsp.data;

  // R3
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !(rpl_valid && rpl_ready)) |=>
      (tgt_valid && $stable(tgt_addr) && $stable(tgt_thread) && $stable(tgt_data)));

  // R4
  rpl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_ready |-> tgt_valid);

  // R5
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_consumed) |=>
      (rsp_valid && $stable(rsp_thread) && $stable(rsp_data)));

  // R2
  req_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && io_req_ready) |=> tgt_valid);
endmodule

// File: tb/iob_bridge_tb.sv
module iob_bridge_tb_top;
  import iob_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req_valid = 1'b0;
  logic io_req_ready;
  logic [TID_W-1:0]  io_req_thread = '0;
  logic [OP_W-1:0]   io_req_op = '0;
  logic [ADDR_W-1:0] io_req_addr = '0;
  logic [DATA_W-1:0] io_req_data = '0;
  logic tgt_valid;
  logic [TID_W-1:0]  tgt_thread;
  logic [OP_W-1:0]   tgt_op;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic rpl_valid = 1'b0;
  logic rpl_ready;
  logic [DATA_W-1:0] rpl_data = '0;
  logic rsp_valid;
  logic [TID_W-1:0]  rsp_thread;
  logic [DATA_W-1:0] rsp_data;
  logic rsp_consumed = 1'b0;

  always #5 clk = ~clk;

  iob_bridge #(.REQ_DEPTH(DEPTH), .RSP_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_thread(io_req_thread), .io_req_op(io_req_op),
    .io_req_addr(io_req_addr), .io_req_data(io_req_data),
    .tgt_valid(tgt_valid), .tgt_thread(tgt_thread), .tgt_op(tgt_op),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
    .rsp_valid(rsp_valid), .rsp_thread(rsp_thread), .rsp_data(rsp_data),
    .rsp_consumed(rsp_consumed)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;
  io_req_t qreq[$];
  io_rsp_t qrsp[$];

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare outputs with the model, then drive one cycle and advance the model.
  task automatic step(input string tag, input bit rv, input bit pv, input bit cons);
    bit acc_req, acc_rpl, do_pop;
    io_req_t nr;
    io_req_t h;
    logic [DATA_W-1:0] rd;
    chk(tag, "io_req_ready", io_req_ready, qreq.size() < DEPTH);
    chk(tag, "tgt_valid", tgt_valid, qreq.size() > 0);
    chk(tag, "rpl_ready", rpl_ready, (qreq.size() > 0) && (qrsp.size() < DEPTH));
    chk(tag, "rsp_valid", rsp_valid, qrsp.size() > 0);
    if (qreq.size() > 0) begin
      chk(tag, "tgt_thread", tgt_thread, qreq[0].thread);
      chk(tag, "tgt_op", tgt_op, qreq[0].op);
      chk(tag, "tgt_addr", tgt_addr, qreq[0].addr);
      chk(tag, "tgt_data", tgt_data, qreq[0].data);
    end
    if (qrsp.size() > 0) begin
      chk(tag, "rsp_thread", rsp_thread, qrsp[0].thread);
      chk(tag, "rsp_data", rsp_data, qrsp[0].data);
    end
    nr.thread = TID_W'($urandom);
    nr.op     = OP_W'($urandom);
    nr.addr   = $urandom;
    nr.data   = $urandom;
    rd        = $urandom;
    acc_req = rv && (qreq.size() < DEPTH);
    acc_rpl = pv && (qreq.size() > 0) && (qrsp.size() < DEPTH);
    do_pop  = cons && (qrsp.size() > 0);
    io_req_valid  = rv;
    io_req_thread = nr.thread;
    io_req_op     = nr.op;
    io_req_addr   = nr.addr;
    io_req_data   = nr.data;
    rpl_valid     = pv;
    rpl_data      = rd;
    rsp_consumed  = cons;
    if (do_pop) void'(qrsp.pop_front());
    if (acc_rpl) begin
      h = qreq.pop_front();
      qrsp.push_back('{thread: h.thread, data: rd});
    end
    if (acc_req) qreq.push_back(nr);
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1", "io_req_ready", io_req_ready, 1);
    chk("R1", "tgt_valid", tgt_valid, 0);
    chk("R1", "rpl_ready", rpl_ready, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    step("R1", 0, 0, 0);
    // R2: fill past capacity, extra offers must vanish
    repeat (11) step("R2", 1, 0, 0);
    // R3: retire a few heads in order
    repeat (3) step("R3", 0, 1, 0);
    // R8: fill response queue, replies then back-pressured
    repeat (14) step("R8", 1, 1, 0);
    // R6: drain and keep pulsing on an empty queue
    repeat (12) step("R6", 0, 0, 1);
    // R7: simultaneous push and pop on both queues
    repeat (4) step("R7", 1, 0, 0);
    repeat (2) step("R7", 1, 1, 0);
    repeat (40) step("R7", 1, 1, 1);
    repeat (10) step("R7", 1, 1, 0);
    repeat (20) step("R7", 1, 1, 1);
    // R4 and R5: random mix
    for (int i = 0; i < 600; i++) begin
      step((i % 2) ? "R4" : "R5",
           ($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 3) == 0);
    end
    step("R5", 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule